// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Tags

This block is the buffer between a serial receiver and the host on a serial controller. Each time the deserializer finishes a character, it pulses a strobe along with the data byte and two error indications: a parity error and a framing error. The block stores the byte and its error tag together as one entry in a first-in first-out queue. The host reads characters one at a time through a data port. It clears sticky status bits through a write port.

The status byte the host sees always includes the error tag of the character now at the front of the queue. Errors of characters further back stay hidden until those characters reach the front. Once a flag is set it stays set until the host clears it. The exception is a flag that belongs to the current front character: such a flag cannot be cleared until that character is read. A single interrupt request line is raised whenever any status bit is set.

Top module: `rxq_err_buffer`

## Requirements
- R1: After a synchronous reset, the queue is empty and the status byte, the interrupt request and the read data are all zero.
- R2: Characters are returned in the order they arrived. The queue holds up to DEPTH (default 8) characters. Read data updates one clock after a read strobe that finds the queue non-empty.
- R3: Status bit 0 (data available) is set whenever the queue holds at least one character. It clears on the read that empties the queue. Writing 1 to bit 0 has no effect.
- R4: A character arriving at an empty queue shows its parity error in status bit 1 and its framing error in status bit 2, one clock after its strobe.
- R5: The error flags of a character that arrives behind others stay out of the status byte. They appear on the clock after the read that moves that character to the front.
- R6: A status write clears every bit among bits 1 to 3 that is written as 1. Bits written as 0 keep their value. Status bits 4 to 7 always read as 0.
- R7: A status write cannot clear an error bit that belongs to the character at the front of the queue. Such a bit remains 1 after the write.
- R8: A character strobe while the queue holds DEPTH characters sets status bit 3 (overrun) and drops that character. A clear of bit 3 in the same cycle loses to the set.
- R9: A read strobe on an empty queue changes neither the read data nor the status byte.
- R10: The interrupt request is 1 exactly when any status bit is 1. It changes in the same cycle as the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | One-cycle strobe: a character has completed |
| chr_data | input | 8 | Completed character byte |
| chr_perr | input | 1 | Parity error of the completed character |
| chr_ferr | input | 1 | Framing error of the completed character |
| rd_en | input | 1 | Host read of the data register |
| st_wr_en | input | 1 | Host write of the status register |
| st_wr_data | input | 8 | Write-one-to-clear mask for the status register |
| rd_data | output | 8 | Last character read from the queue |
| status | output | 8 | Status: bit0 available, bit1 parity, bit2 framing, bit3 overrun |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge, and that the strobe inputs are held low while reset is active. They also assume that a status write is one host operation lasting a single cycle, not a level held across many cycles. The stimulus drives all inputs at falling edges and keeps them low during reset. It pulses each strobe for exactly one cycle, and it runs one host operation at a time, except in one deliberate cycle that combines an overrun with a clear of the overrun bit. With this discipline, the overrun and clear properties only see the input combinations that those properties describe.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 8;

  localparam logic [STAT_W-1:0] ST_AVAIL = 8'h01;
  localparam logic [STAT_W-1:0] ST_PERR  = 8'h02;
  localparam logic [STAT_W-1:0] ST_FERR  = 8'h04;
  localparam logic [STAT_W-1:0] ST_OVRN  = 8'h08;
  localparam logic [STAT_W-1:0] ST_ERRS  = ST_PERR | ST_FERR;
  localparam logic [STAT_W-1:0] ST_IMPL  = ST_AVAIL | ST_ERRS | ST_OVRN;

  // one queue slot: tag in the upper byte, character in the lower byte
  typedef struct packed {
    logic [STAT_W-1:0] tag;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  function automatic logic [STAT_W-1:0] make_tag(input logic perr, input logic ferr);
    return (perr ? ST_PERR : '0) | (ferr ? ST_FERR : '0);
  endfunction
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          do_push,
  output logic          do_pop,
  output logic          ovr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] rd_ptr_nx,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic full, empty;

  assign full      = (cnt == FULL_CNT);
  assign empty     = (cnt == '0);
  assign do_push   = push_req & ~full;
  assign do_pop    = pop_req & ~empty;
  assign ovr       = push_req & full;
  assign rd_ptr_nx = rd_ptr + AW'(1);

  always_comb begin
    case ({do_push, do_pop})
      2'b10:   cnt_nx = cnt + CW'(1);
      2'b01:   cnt_nx = cnt - CW'(1);
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr_nx;
      cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  rxq_entry_t        wentry,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  input  logic [AW-1:0]     la_addr1,
  output logic [DATA_W-1:0] rd_byte,
  output logic [STAT_W-1:0] tag_head,
  output logic [STAT_W-1:0] tag_next
);
  // character bytes: synchronous write and read, no reset, RAM-inferable
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) data_mem[waddr] <= wentry.data;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_byte <= '0;
    else if (re) rd_byte <= data_mem[raddr];
  end

  // error tags: flop slots with combinational lookahead for the front two entries
  logic [DEPTH-1:0][STAT_W-1:0] tag_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag_slot
    logic [STAT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                            slot_q <= '0;
      else if (we && waddr == AW'(g))     slot_q <= wentry.tag & ST_ERRS;
    end
    assign tag_vec[g] = slot_q;
  end

  assign tag_head = tag_vec[raddr];
  assign tag_next = tag_vec[la_addr1];
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              ovr,
  input  logic              head_valid,
  input  logic [STAT_W-1:0] head_tag,
  output logic [STAT_W-1:0] status_q,
  output logic              irq_q
);
  logic [STAT_W-1:0] clr_mask, kept, front, nx;

  always_comb begin
    clr_mask = wr_en ? (wr_data & ~ST_AVAIL) : '0;
    kept     = status_q & ~clr_mask & ~ST_AVAIL;
    front    = head_valid ? ((head_tag & ST_ERRS) | ST_AVAIL) : '0;
    nx       = (kept | front | (ovr ? ST_OVRN : '0)) & ST_IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= nx;
      irq_q    <= |nx;
    end
  end
endmodule

// File: rtl/rxq_err_buffer.sv
module rxq_err_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chr_valid,
  input  logic [7:0] chr_data,
  input  logic       chr_perr,
  input  logic       chr_ferr,
  input  logic       rd_en,
  input  logic       st_wr_en,
  input  logic [7:0] st_wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       rx_irq
);
  logic          do_push, do_pop, ovr;
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt, cnt_nx;
  rxq_entry_t    in_entry;
  logic [STAT_W-1:0] tag_head, tag_next, head_tag_nx;

  assign in_entry.data = chr_data;
  assign in_entry.tag  = make_tag(chr_perr, chr_ferr);

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .push_req  (chr_valid),
    .pop_req   (rd_en),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .ovr       (ovr),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .rd_ptr_nx (rd_ptr_nx),
    .cnt       (cnt),
    .cnt_nx    (cnt_nx)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (do_push),
    .waddr    (wr_ptr),
    .wentry   (in_entry),
    .re       (do_pop),
    .raddr    (rd_ptr),
    .la_addr1 (rd_ptr_nx),
    .rd_byte  (rd_data),
    .tag_head (tag_head),
    .tag_next (tag_next)
  );

  // tag of the entry that will sit at the front after this cycle
  always_comb begin
    if (cnt_nx == '0)          head_tag_nx = '0;
    else if (do_pop)           head_tag_nx = (cnt > CW'(1)) ? tag_next : in_entry.tag;
    else if (cnt == '0)        head_tag_nx = in_entry.tag;
    else                       head_tag_nx = tag_head;
  end

  rxq_status u_status (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (st_wr_en),
    .wr_data    (st_wr_data),
    .ovr        (ovr),
    .head_valid (cnt_nx != '0),
    .head_tag   (head_tag_nx),
    .status_q   (status),
    .irq_q      (rx_irq)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   chr_valid,
  input logic                   rd_en,
  input logic                   st_wr_en,
  input logic [7:0]             st_wr_data,
  input logic [7:0]             rd_data,
  input logic [7:0]             status,
  input logic                   rx_irq,
  input logic [$clog2(DEPTH):0] fill
);
  assert_avail_after_char_R3: assert property (@(posedge clk) disable iff (rst)
    chr_valid |=> status[0]);

  assert_avail_matches_fill_R3: assert property (@(posedge clk) disable iff (rst)
    status[0] == (fill != 0));

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_overrun_on_full_R8: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && fill == ($clog2(DEPTH)+1)'(DEPTH)) |=> status[3]);

  assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (st_wr_en && st_wr_data[3] && !(chr_valid && fill == ($clog2(DEPTH)+1)'(DEPTH))) |=> !status[3]);

  assert_empty_read_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !status[0]) |=> $stable(rd_data));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    status[7:4] == 4'h0);

  assert_irq_tracks_status_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq == (status != 8'h00));
endmodule

bind rxq_err_buffer rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
  .clk        (clk),
  .rst        (rst),
  .chr_valid  (chr_valid),
  .rd_en      (rd_en),
  .st_wr_en   (st_wr_en),
  .st_wr_data (st_wr_data),
  .rd_data    (rd_data),
  .status     (status),
  .rx_irq     (rx_irq),
  .fill       (cnt)
);

// File: tb/test_rxq_err_buffer.sv
module test_rxq_err_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = 8'h00;
  logic       chr_perr = 1'b0;
  logic       chr_ferr = 1'b0;
  logic       rd_en = 1'b0;
  logic       st_wr_en = 1'b0;
  logic [7:0] st_wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] status;
  logic       rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] sb_q[$];

  always #2.5 clk = ~clk;

  rxq_err_buffer i_rxq_err_buffer (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_perr(chr_perr), .chr_ferr(chr_ferr), .rd_en(rd_en),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .rd_data(rd_data), .status(status), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_st(input string req, input logic [7:0] exp);
    chk(req, status, exp);
    chk({req, " irq (R10)"}, {7'd0, rx_irq}, {7'd0, exp != 8'h00});
  endtask

  task automatic push_char(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = d; chr_perr = pe; chr_ferr = fe;
    if (sb_q.size() < 8) sb_q.push_back(d);
    @(negedge clk);
    chr_valid = 1'b0; chr_perr = 1'b0; chr_ferr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] m);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = m;
    @(negedge clk);
    st_wr_en = 1'b0; st_wr_data = 8'h00;
  endtask

  // monitor: each accepted read pops the scoreboard and compares read data (R2)
  always @(posedge clk) begin
    if (!rst && rd_en === 1'b1 && sb_q.size() > 0) begin
      automatic logic [7:0] exp = sb_q.pop_front();
      #1;
      chk("R2 read order", rd_data, exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk_st("R1 reset status", 8'h00);

    host_read();
    chk("R9 empty read data", rd_data, 8'h00);
    chk_st("R9 empty read status", 8'h00);

    push_char(8'hA5, 1'b0, 1'b0);
    chk_st("R3 avail on enqueue", 8'h01);
    push_char(8'h3C, 1'b1, 1'b0);
    chk_st("R5 hidden tag behind head", 8'h01);
    host_read();
    chk_st("R5 tag appears at head", 8'h03);
    host_write(8'h02);
    chk_st("R7 head tag survives clear", 8'h03);
    host_write(8'h01);
    chk_st("R3 avail ignores write", 8'h03);
    host_read();
    chk_st("R3 avail clears when empty", 8'h02);
    host_write(8'h02);
    chk_st("R6 clear parity", 8'h00);

    push_char(8'h77, 1'b0, 1'b1);
    chk_st("R4 framing to empty queue", 8'h05);
    host_read();
    chk_st("R4 after read", 8'h04);
    host_write(8'h04);
    chk_st("R6 clear framing", 8'h00);

    for (int i = 0; i < 8; i++) push_char(8'h10 + 8'(i), 1'b0, 1'b0);
    chk_st("R2 full queue", 8'h01);
    push_char(8'h99, 1'b1, 1'b1);
    chk_st("R8 overrun set", 8'h09);
    // overrun again while clearing bit 3 in the same cycle: set wins
    @(negedge clk);
    chr_valid = 1'b1; chr_data = 8'h98; st_wr_en = 1'b1; st_wr_data = 8'h08;
    @(negedge clk);
    chr_valid = 1'b0; st_wr_en = 1'b0; st_wr_data = 8'h00;
    chk_st("R8 set beats clear", 8'h09);

    for (int i = 0; i < 8; i++) host_read();
    chk("R8 dropped char not stored", rd_data, 8'h17);
    chk_st("R8 overrun sticky", 8'h08);
    host_read();
    chk("R9 empty read keeps data", rd_data, 8'h17);
    chk_st("R9 empty read keeps status", 8'h08);
    host_write(8'h00);
    chk_st("R6 zero write keeps bits", 8'h08);
    host_write(8'hFF);
    chk_st("R6 clear all", 8'h00);
    chk("R2 scoreboard drained", 8'(sb_q.size()), 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule